// File: doc/BRIEF.md
# Majority-Clocked LFSR Keystream Generator

This block turns a 64-bit session key and a 22-bit frame number into the 228 keystream bits of one frame. It does this one bit per clock with three linear feedback shift registers of 19, 22 and 23 bits. A start pulse captures both inputs, clears the registers and runs the loading sequence. In that sequence all three registers step together, first with each key bit and then with each frame bit mixed into their feedback.

Next comes a warm-up of 100 irregular steps whose output is thrown away. Then 228 irregular steps follow, and each one yields a keystream bit with a valid strobe. In an irregular step, a register advances only when its clocking bit agrees with the majority of the three clocking bits. A done flag then stays high until the next start. Combining the keystream with data happens outside this block.

Top module: `mcl_keystream_gen`

## Requirements
- R1: When a register steps, bit j takes bit j-1 and bit 0 takes the XOR of its taps, plus the injected bit during loading. The taps are {13,16,17,18} for the 19-bit register, {20,21} for the 22-bit register and {7,20,21,22} for the 23-bit register. A register that does not step holds its value.
- R2: In the warm-up and output phases, the clocking bits are bit 8, bit 10 and bit 10 of the 19-, 22- and 23-bit registers. Only the registers whose clocking bit equals the majority of the three step, so at least two step each cycle.
- R3: A start pulse that is accepted captures key_i and frame_i and clears all three registers. Key bits 0 through 63 are then injected into every feedback, least significant bit first, one per cycle over 64 cycles with all registers stepping. Changes on key_i after the start have no effect.
- R4: Right after the key bits, frame_i bits 0 through 21 are injected the same way over 22 cycles, again with all registers stepping.
- R5: 100 majority-clocked warm-up cycles follow, with ks_valid_o low throughout. The first ks_valid_o appears after the 187th rising edge that follows the edge which sampled start_i.
- R6: Exactly 228 consecutive cycles carry ks_valid_o high. Each ks_bit_o is the XOR of the three register MSBs, taken after that cycle's majority step.
- R7: ks_bit_o is 0 whenever ks_valid_o is low. done_o rises one cycle after the last valid bit and stays high until a new start is accepted. done_o and ks_valid_o are never high together.
- R8: start_i is ignored while a frame is being produced, and the keystream of the running frame is not changed by it. After done_o, a start begins a new frame.
- R9: After reset, ks_valid_o, ks_bit_o and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame (accepted when idle or done) |
| key_i | input | KEY_BITS (64) | Session key, sampled on start |
| frame_i | input | FRAME_BITS (22) | Frame number, sampled on start |
| ks_bit_o | output | 1 | Keystream bit |
| ks_valid_o | output | 1 | Keystream bit valid |
| done_o | output | 1 | Frame finished, held until next start |

## Verification
The assertions rely on start_i being a synchronous level that is sampled only at rising edges. They also rely on key_i and frame_i mattering only on the edge that accepts start. The bench drives all inputs on falling edges and deliberately scrambles key_i and frame_i after each start. It also pulses start_i in the middle of a frame, so that the states the assertions treat as legal, including an ignored start, are really reached. Expected keystreams come from an independent bit-level model of the three registers in the bench. The all-zero key and frame is included because it locks every register at zero.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LOAD,
      PH_WARM,
      PH_RUN,
      PH_DONE
   } phase_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/mcl_lfsr.sv
module mcl_lfsr #(
   parameter int          LEN     = 19,
   parameter int          CLK_IDX = 8,
   parameter logic [31:0] TAPS    = 32'h0007_2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   input  logic inj_i,
   output logic clk_bit_o,
   output logic msb_o
);
   generate
      if (LEN < 2 || LEN > 32) begin : g_bad_len
         $error("mcl_lfsr: LEN out of range");
      end
      if (CLK_IDX < 0 || CLK_IDX >= LEN) begin : g_bad_clk
         $error("mcl_lfsr: CLK_IDX outside register");
      end
      if (TAPS[LEN-1] != 1'b1) begin : g_bad_taps
         $error("mcl_lfsr: MSB must be a tap");
      end
   endgenerate

   logic [LEN-1:0] q;
   logic [LEN-1:0] tapv;
   logic           fb;

   genvar g;
   generate
      for (g = 0; g < LEN; g++) begin : g_tap
         if (TAPS[g]) begin : g_on
            assign tapv[g] = q[g];
         end else begin : g_off
            assign tapv[g] = 1'b0;
         end
      end
   endgenerate

   assign fb = (^tapv) ^ inj_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (clear_i) q <= '0;
      else if (step_i)  q <= {q[LEN-2:0], fb};
   end

   assign clk_bit_o = q[CLK_IDX];
   assign msb_o     = q[LEN-1];

   // R1: a step moves the upper bits up by one place
   assert_shift_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !clear_i) |=> (q[LEN-1] == $past(q[LEN-2])));
   // R1: a register left unstepped keeps its content
   assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !clear_i) |=> $stable(q));
   // R3: clear empties the register
   assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (q == '0));
endmodule

// File: rtl/mcl_seq.sv
module mcl_seq
   import mcl_pkg::*;
#(
   parameter int LOAD_CYC = 86,
   parameter int WARM_CYC = 100,
   parameter int RUN_CYC  = 228
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_i,
   output phase_t phase_o,
   output logic   accept_o,
   output logic   linear_o,
   output logic   majority_o,
   output logic   run_o
);
   localparam int MAXC = max3(LOAD_CYC, WARM_CYC, RUN_CYC);
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (LOAD_CYC < 1 || WARM_CYC < 1 || RUN_CYC < 1) begin : g_bad_len
         $error("mcl_seq: phase lengths must be positive");
      end
   endgenerate

   phase_t        phase;
   logic [CW-1:0] cnt;

   assign accept_o   = start_i && (phase == PH_IDLE || phase == PH_DONE);
   assign linear_o   = (phase == PH_LOAD);
   assign majority_o = (phase == PH_WARM) || (phase == PH_RUN);
   assign run_o      = (phase == PH_RUN);
   assign phase_o    = phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE, PH_DONE: begin
               if (start_i) begin
                  phase <= PH_LOAD;
                  cnt   <= '0;
               end
            end
            PH_LOAD: begin
               if (cnt == CW'(LOAD_CYC - 1)) begin
                  phase <= PH_WARM;
                  cnt   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_WARM: begin
               if (cnt == CW'(WARM_CYC - 1)) begin
                  phase <= PH_RUN;
                  cnt   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_RUN: begin
               if (cnt == CW'(RUN_CYC - 1)) begin
                  phase <= PH_DONE;
                  cnt   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            default: begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   // R8: a start seen mid-frame does not rewind the sequence
   assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && majority_o) |=> (phase != PH_LOAD));
   // R5: warm-up hands over to output, never straight to done
   assert_warm_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WARM) |=> (phase == PH_WARM || phase == PH_RUN));
   // R4: loading never runs past its cycle count
   assert_load_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOAD) |-> (cnt < CW'(LOAD_CYC)));
endmodule

// File: rtl/mcl_keystream_gen.sv
module mcl_keystream_gen
   import mcl_pkg::*;
#(
   parameter int KEY_BITS   = 64,
   parameter int FRAME_BITS = 22,
   parameter int WARM_CYC   = 100,
   parameter int RUN_CYC    = 228
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [KEY_BITS-1:0]   key_i,
   input  logic [FRAME_BITS-1:0] frame_i,
   output logic                  ks_bit_o,
   output logic                  ks_valid_o,
   output logic                  done_o
);
   localparam int LOAD_CYC = KEY_BITS + FRAME_BITS;

   generate
      if (KEY_BITS < 1 || FRAME_BITS < 1) begin : g_bad_inputs
         $error("mcl_keystream_gen: key and frame widths must be positive");
      end
   endgenerate

   phase_t phase;
   logic   accept, linear, majority, run;

   mcl_seq #(
      .LOAD_CYC (LOAD_CYC),
      .WARM_CYC (WARM_CYC),
      .RUN_CYC  (RUN_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .phase_o    (phase),
      .accept_o   (accept),
      .linear_o   (linear),
      .majority_o (majority),
      .run_o      (run)
   );

   // Load bits, consumed from bit 0 upward: key first, then frame
   logic [LOAD_CYC-1:0] ld_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ld_q <= '0;
      else if (accept) ld_q <= {frame_i, key_i};
      else if (linear) ld_q <= {1'b0, ld_q[LOAD_CYC-1:1]};
   end

   logic inj;
   assign inj = linear & ld_q[0];

   logic cb_a, cb_b, cb_c, msb_a, msb_b, msb_c;
   logic maj, st_a, st_b, st_c;

   assign maj  = (cb_a & cb_b) | (cb_a & cb_c) | (cb_b & cb_c);
   assign st_a = linear | (majority & (cb_a == maj));
   assign st_b = linear | (majority & (cb_b == maj));
   assign st_c = linear | (majority & (cb_c == maj));

   mcl_lfsr #(.LEN(19), .CLK_IDX(8),  .TAPS(32'h0007_2000)) u_ra (
      .clk(clk), .rst_n(rst_n), .clear_i(accept), .step_i(st_a),
      .inj_i(inj), .clk_bit_o(cb_a), .msb_o(msb_a));
   mcl_lfsr #(.LEN(22), .CLK_IDX(10), .TAPS(32'h0030_0000)) u_rb (
      .clk(clk), .rst_n(rst_n), .clear_i(accept), .step_i(st_b),
      .inj_i(inj), .clk_bit_o(cb_b), .msb_o(msb_b));
   mcl_lfsr #(.LEN(23), .CLK_IDX(10), .TAPS(32'h0070_0080)) u_rc (
      .clk(clk), .rst_n(rst_n), .clear_i(accept), .step_i(st_c),
      .inj_i(inj), .clk_bit_o(cb_c), .msb_o(msb_c));

   // Valid marks the cycle after each output step; bit read after that step
   logic valid_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= run;
   end

   assign ks_valid_o = valid_q;
   assign ks_bit_o   = valid_q & (msb_a ^ msb_b ^ msb_c);
   assign done_o     = (phase == PH_DONE) & ~valid_q;

   // R2: each irregular cycle advances two or three registers
   assert_two_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      majority |-> ($countones({st_a, st_b, st_c}) >= 2));
   // R6: valid only follows an output-phase step
   assert_valid_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ks_valid_o |-> $past(run));
   // R7: done and valid are exclusive
   assert_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && ks_valid_o));
   // R7: done holds until a new start
   assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o);
   // R7: output quiet without valid
   assert_quiet_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ks_valid_o |-> !ks_bit_o);
endmodule

// File: tb/tb_mcl_keystream_gen.sv
`timescale 1ns/1ps
module tb_mcl_keystream_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [63:0] key_i = '0;
   logic [21:0] frame_i = '0;
   logic        ks_bit_o, ks_valid_o, done_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic exp_ks [0:227];
   logic got_ks [0:227];

   always #4 clk = ~clk;

   mcl_keystream_gen dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
      .frame_i(frame_i), .ks_bit_o(ks_bit_o), .ks_valid_o(ks_valid_o),
      .done_o(done_o));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Independent model of the three registers
   task automatic model(input logic [63:0] k, input logic [21:0] f);
      logic [18:0] a;
      logic [21:0] b;
      logic [22:0] c;
      a = '0; b = '0; c = '0;
      for (int i = 0; i < 86; i++) begin
         logic inj;
         inj = (i < 64) ? k[i] : f[i-64];
         a = {a[17:0], a[13] ^ a[16] ^ a[17] ^ a[18] ^ inj};
         b = {b[20:0], b[20] ^ b[21] ^ inj};
         c = {c[21:0], c[7] ^ c[20] ^ c[21] ^ c[22] ^ inj};
      end
      for (int i = 0; i < 328; i++) begin
         logic m;
         m = (a[8] & b[10]) | (a[8] & c[10]) | (b[10] & c[10]);
         if (a[8] == m)  a = {a[17:0], a[13] ^ a[16] ^ a[17] ^ a[18]};
         if (b[10] == m) b = {b[20:0], b[20] ^ b[21]};
         if (c[10] == m) c = {c[21:0], c[7] ^ c[20] ^ c[21] ^ c[22]};
         if (i >= 100) exp_ks[i-100] = a[18] ^ b[21] ^ c[22];
      end
   endtask

   // Runs one frame; poke_at >= 0 pulses start mid-frame at that cycle
   task automatic run_frame(input logic [63:0] k, input logic [21:0] f, input int poke_at);
      int vbad, dbad, bbad, nval;
      vbad = 0; dbad = 0; bbad = 0; nval = 0;
      model(k, f);
      @(negedge clk);
      key_i = k; frame_i = f; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      key_i = ~k; frame_i = ~f;   // R3: later changes must not matter
      for (int n = 1; n <= 420; n++) begin
         if (n == poke_at) start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         if (ks_valid_o !== ((n >= 187) && (n <= 414))) vbad++;
         if (done_o !== (n >= 415)) dbad++;
         if (ks_valid_o === 1'b1) begin
            if (nval < 228) got_ks[nval] = ks_bit_o;
            nval++;
         end else if (ks_bit_o !== 1'b0) bbad++;
      end
      for (int i = 0; i < 228; i++) if (got_ks[i] !== exp_ks[i]) bbad++;
      check(vbad == 0, "R5 valid window", vbad, 0);
      check(nval == 228, "R6 valid count", nval, 228);
      check(bbad == 0, "R1 R2 R3 R4 R6 keystream bits", bbad, 0);
      check(dbad == 0, "R7 done timing", dbad, 0);
   endtask

   task automatic test_reset();
      check(ks_valid_o === 1'b0, "R9 valid after reset", ks_valid_o, 0);
      check(ks_bit_o === 1'b0, "R9 bit after reset", ks_bit_o, 0);
      check(done_o === 1'b0, "R9 done after reset", done_o, 0);
   endtask

   task automatic test_zero_key();
      int ones;
      ones = 0;
      run_frame('0, '0, -1);
      for (int i = 0; i < 228; i++) if (got_ks[i] !== 1'b0) ones++;
      check(ones == 0, "R3 zero key gives zero stream", ones, 0);
   endtask

   task automatic test_done_hold();
      int drop;
      drop = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (done_o !== 1'b1 || ks_valid_o !== 1'b0) drop++;
      end
      check(drop == 0, "R7 done held while idle", drop, 0);
   endtask

   task automatic test_single_bit_key();
      int same;
      logic saved [0:227];
      same = 0;
      run_frame(64'h1, 22'h0, -1);
      for (int i = 0; i < 228; i++) saved[i] = got_ks[i];
      run_frame(64'h8000_0000_0000_0000, 22'h0, -1);
      for (int i = 0; i < 228; i++) if (saved[i] === got_ks[i]) same++;
      check(same != 228, "R3 key bit order matters", same, 0);
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      run_frame(64'h0123_4567_89AB_CDEF, 22'h13_4A5C, -1);
      test_done_hold();
      run_frame(64'hFEDC_BA98_7654_3210, 22'h00_0001, 40);   // R8 poke during load
      run_frame(64'h5A5A_0F0F_C3C3_9669, 22'h3F_FFFF, 300);  // R8 poke during output
      test_zero_key();
      test_single_bit_key();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule